// File: doc/BRIEF.md
# Character Height Line-Repeat Scaler

This block stretches a character cell that is 18 font lines tall to a chosen number of scanlines. It does this by emitting some font lines more than once. A display controller pulses `row_start` when a character row begins and pulses `line_stb` once per scanline. On each scanline the block presents the font line index to fetch from the glyph store. It flags the final scanline of the row so the controller can move to the next row.

A six-bit height code selects a band. The band sets the base number of copies that every font line receives, from one to four. Inside the band, a step value `m` picks which lines get one further copy: the lines at index 2 + n·m for n ≥ 1, up to and including index 16. The step is the band offset divided into 14, rounded to the nearest integer with halves rounding up. The block samples the code and the derived band values when `row_start` arrives, so a code that changes in the middle of a row takes effect only on the next row.

Top module: `osd_char_vscale`

## Requirements
- R1: After reset `row_busy` is 0, `font_line` is 0 and `row_last` is 0.
- R2: The cycle after `row_start` is sampled high, `row_busy` is 1 and `font_line` is 0, holding the first copy of line 0.
- R3: A height code of 18 or less gives an unscaled row: each of the 18 font lines appears for exactly one scanline, so the row is 18 scanlines long.
- R4: The base copy count per font line depends on the code: 1 for codes 19 to 32, 2 for codes 33 to 46, 3 for codes 47 to 60 and 4 for codes 61 to 63.
- R5: The band offset k is the code minus 18, 32, 46 or 60, according to the band in R4. With m = round(14/k), halves rounding up, the lines at index 2 + n·m (n ≥ 1) receive one copy beyond the base count. Code 32 therefore gives 32 scanlines.
- R6: No font line with an index above 16 receives an extra copy.
- R7: `font_line` runs from 0 to 17 without skipping or stepping back. Every `line_stb` while busy moves the row forward by one scanline, and all copies of one line are consecutive.
- R8: `row_last` is 1 only on the last scanline of line 17. A `line_stb` on that scanline ends the row: `row_busy` falls and `font_line` returns to 0.
- R9: A change of `height_code` during a row does not change that row's scanline sequence.
- R10: When `row_start` and `line_stb` are high in the same cycle, `row_start` wins and the row restarts at the first copy of line 0.
- R11: `line_stb` while `row_busy` is 0 has no effect: `row_busy` and `font_line` stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| height_code | input | 6 | Requested cell height in scanlines |
| row_start | input | 1 | Pulse that begins a character row and samples the code |
| line_stb | input | 1 | Pulse that advances by one scanline |
| font_line | output | 5 | Font line index for the current scanline |
| row_busy | output | 1 | High while a row is being emitted |
| row_last | output | 1 | High on the final scanline of the row |

## Verification
Two events can arrive in the same cycle: a row restart and a scanline advance. The bench first walks a row part of the way, then raises `row_start` and `line_stb` together. The next cycle must show line 0 with the row busy. The complete row that follows must have the scanline count given by the code, which shows the restart won and no half-advanced state survived. A second collision changes `height_code` in the middle of a row. Here the bench judges that the length and line sequence of that row still match the code that was sampled at its start.

// File: rtl/osd_vscale_pkg.sv
package osd_vscale_pkg;
    localparam int FONT_LINES  = 18;
    localparam int CODE_W      = 6;
    localparam int BAND_SPAN   = 14;
    localparam int NUM_BANDS   = 4;
    localparam int FIRST_EXTRA = 2;
    localparam int LAST_EXTRA  = FONT_LINES - 2;
    localparam int LINE_W      = $clog2(FONT_LINES);
    localparam int REP_W       = $clog2(NUM_BANDS + 2);
    localparam int STEP_W      = $clog2(BAND_SPAN + 1);

    typedef struct packed {
        logic              busy;
        logic [LINE_W-1:0] line;
        logic [REP_W-1:0]  rep;
        logic [REP_W-1:0]  base;
        logic [STEP_W-1:0] step;
        logic [LINE_W:0]   next_extra;
    } seq_state_t;
endpackage

// File: rtl/osd_vscale_band.sv
module osd_vscale_band
    import osd_vscale_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [REP_W-1:0]  base_o,
    output logic [STEP_W-1:0] step_o
);
    int base_v;
    int ofs_v;
    int cnt_v;

    // Band select: the highest threshold the code exceeds decides the base copy count.
    always_comb begin
        base_v = 1;
        ofs_v  = 0;
        for (int j = 0; j < NUM_BANDS; j++) begin
            if (int'(code_i) > FONT_LINES + j * BAND_SPAN) begin
                base_v = j + 1;
                ofs_v  = int'(code_i) - FONT_LINES - j * BAND_SPAN;
            end
        end
    end

    // Rounded quotient SPAN/ofs, halves up: count q with 2*ofs*q <= 2*SPAN + ofs.
    always_comb begin
        cnt_v = 0;
        if (ofs_v > 0) begin
            for (int q = 1; q <= BAND_SPAN; q++) begin
                if (2 * ofs_v * q <= 2 * BAND_SPAN + ofs_v) cnt_v = cnt_v + 1;
            end
        end
    end

    assign base_o = REP_W'(base_v);
    assign step_o = STEP_W'(cnt_v);
endmodule

// File: rtl/osd_vscale_seq.sv
module osd_vscale_seq
    import osd_vscale_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_start_i,
    input  logic              line_stb_i,
    input  logic [REP_W-1:0]  base_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [LINE_W-1:0] line_o,
    output logic              busy_o,
    output logic              last_o
);
    seq_state_t q, d;
    logic             extra;
    logic [REP_W-1:0] reps;
    logic             last_copy;
    logic             row_done;

    always_comb begin
        extra     = (q.step != '0) && ({1'b0, q.line} == q.next_extra)
                    && (q.line <= LINE_W'(LAST_EXTRA));
        reps      = q.base + REP_W'(extra);
        last_copy = ((q.rep + REP_W'(1)) == reps);
        row_done  = q.busy && last_copy && (q.line == LINE_W'(FONT_LINES - 1));

        d = q;
        if (row_start_i) begin
            d.busy       = 1'b1;
            d.line       = '0;
            d.rep        = '0;
            d.base       = base_i;
            d.step       = step_i;
            d.next_extra = (LINE_W + 1)'(FIRST_EXTRA) + (LINE_W + 1)'(step_i);
        end else if (line_stb_i && q.busy) begin
            if (!last_copy) begin
                d.rep = q.rep + REP_W'(1);
            end else begin
                d.rep = '0;
                if (extra) d.next_extra = q.next_extra + (LINE_W + 1)'(q.step);
                if (q.line == LINE_W'(FONT_LINES - 1)) begin
                    d.busy = 1'b0;
                    d.line = '0;
                end else begin
                    d.line = q.line + LINE_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign line_o = q.line;
    assign busy_o = q.busy;
    assign last_o = row_done;

    // R2: a row start lands on the first copy of line 0
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        row_start_i |=> (q.busy && q.line == '0 && q.rep == '0));

    // R7: a scanline advance moves the index by at most one
    a_r7_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && line_stb_i && !row_start_i && !last_o)
        |=> (q.busy && (q.line == $past(q.line) || q.line == $past(q.line) + LINE_W'(1))));

    // R8: advancing from the final scanline closes the row
    a_r8_close: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && line_stb_i && !row_start_i) |=> (!q.busy && q.line == '0));

    // R9: band values stay frozen for the whole row
    a_r9_hold_params: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !row_start_i) |=> ($stable(q.base) && $stable(q.step)));

    // R11: with no row open, a strobe leaves the state alone
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && !row_start_i) |=> (!q.busy && $stable(q.line)));

    // R6: a copy beyond the base count occurs only on lines up to 16
    a_r6_extra_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.rep >= q.base) |-> (q.line <= LINE_W'(LAST_EXTRA)));

    // R4: the copy counter never passes base plus one extra
    a_r4_rep_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.rep <= q.base));
endmodule

// File: rtl/osd_char_vscale.sv
module osd_char_vscale
    import osd_vscale_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] height_code,
    input  logic              row_start,
    input  logic              line_stb,
    output logic [LINE_W-1:0] font_line,
    output logic              row_busy,
    output logic              row_last
);
    logic [REP_W-1:0]  band_base;
    logic [STEP_W-1:0] band_step;

    osd_vscale_band i_band (
        .code_i (height_code),
        .base_o (band_base),
        .step_o (band_step)
    );

    osd_vscale_seq i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_start_i (row_start),
        .line_stb_i  (line_stb),
        .base_i      (band_base),
        .step_i      (band_step),
        .line_o      (font_line),
        .busy_o      (row_busy),
        .last_o      (row_last)
    );
endmodule

// File: tb/test_osd_char_vscale.sv
module test_osd_char_vscale;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] height_code = 6'd0;
    logic       row_start = 1'b0;
    logic       line_stb = 1'b0;
    logic [4:0] font_line;
    logic       row_busy;
    logic       row_last;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    localparam int NV = 17;
    // height code, hand-computed total scanlines
    localparam int VCODE [NV] = '{0, 18, 19, 20, 21, 22, 25, 32, 33, 40, 46, 47, 55, 60, 61, 62, 63};
    localparam int VTOT  [NV] = '{18, 18, 19, 20, 20, 21, 25, 32, 37, 43, 50, 55, 61, 68, 73, 74, 74};

    always #10 clk = ~clk;

    osd_char_vscale i_osd_char_vscale (
        .clk(clk), .rst_n(rst_n), .height_code(height_code),
        .row_start(row_start), .line_stb(line_stb),
        .font_line(font_line), .row_busy(row_busy), .row_last(row_last)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_reps(int code, int l);
        int b = 1;
        int k = 0;
        int m = 0;
        if (code > 60)      begin b = 4; k = code - 60; end
        else if (code > 46) begin b = 3; k = code - 46; end
        else if (code > 32) begin b = 2; k = code - 32; end
        else if (code > 18) begin b = 1; k = code - 18; end
        if (k > 0) m = $rtoi(14.0 / real'(k) + 0.5);
        if (m > 0 && l >= 2 + m && l <= 16 && ((l - 2) % m) == 0) return b + 1;
        return b;
    endfunction

    task automatic strobe();
        line_stb = 1'b1;
        @(negedge clk);
        line_stb = 1'b0;
    endtask

    task automatic start_row(int code);
        height_code = 6'(code);
        row_start = 1'b1;
        @(negedge clk);
        row_start = 1'b0;
    endtask

    // Walk the rest of a row from scanline n0, comparing with the model sequence.
    task automatic walk(int code, int n0, int total, string tag);
        int seqv [100];
        int idx = 0;
        int n = n0;
        int mism = 0;
        int lastpos = -1;
        int lastcnt = 0;
        for (int l = 0; l < 18; l++)
            for (int c = 0; c < exp_reps(code, l); c++) begin
                if (idx < 100) seqv[idx] = l;
                idx++;
            end
        while (row_busy && n < 100) begin
            if (n < total && int'(font_line) != seqv[n]) mism++;
            if (row_last) begin lastpos = n; lastcnt++; end
            strobe();
            n++;
        end
        check(n == total, {tag, " R4 R5 scanline total"}, n, total);
        check(mism == 0, {tag, " R5 R7 line sequence mismatches"}, mism, 0);
        check(lastpos == total - 1 && lastcnt == 1, {tag, " R8 row_last position"}, lastpos, total - 1);
        check(!row_busy && font_line == 5'd0, {tag, " R8 idle after row"}, int'(row_busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!row_busy && font_line == 5'd0 && !row_last, "R1 reset outputs", int'(font_line), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!row_busy && font_line == 5'd0 && !row_last, "R1 after reset release", int'(row_busy), 0);

        // R11: strobe with no open row
        strobe();
        strobe();
        check(!row_busy && font_line == 5'd0, "R11 idle strobe ignored", int'(font_line), 0);

        // Table walk: R3 (codes 0, 18), R4 bands, R5 steps incl. half rounding (22), R6 (19, 21, 63)
        for (int v = 0; v < NV; v++) begin
            start_row(VCODE[v]);
            check(row_busy && font_line == 5'd0, "R2 row start state", int'(font_line), 0);
            walk(VCODE[v], 0, VTOT[v], $sformatf("code%0d", VCODE[v]));
        end

        // R9: code change mid-row has no effect on the open row
        start_row(19);
        for (int i = 0; i < 3; i++) strobe();
        height_code = 6'd63;
        walk(19, 3, 19, "R9 midrow code change");

        // R10: row_start and line_stb together restart the row
        start_row(25);
        for (int i = 0; i < 5; i++) strobe();
        row_start = 1'b1;
        line_stb = 1'b1;
        @(negedge clk);
        row_start = 1'b0;
        line_stb = 1'b0;
        check(row_busy && font_line == 5'd0, "R10 collision restarts at line 0", int'(font_line), 0);
        walk(25, 0, 25, "R10 after collision");

        // R2: row_start mid-row with a new code
        start_row(40);
        for (int i = 0; i < 9; i++) strobe();
        start_row(33);
        check(row_busy && font_line == 5'd0, "R2 restart mid-row", int'(font_line), 0);
        walk(33, 0, 37, "R2 restart code33");

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule